// File: doc/BRIEF.md
# Direct Digital Synthesis Sine Generator with Control Word Loader

This block turns a 40-bit control word into a digitally generated sine wave. The low 32 bits of the word form a frequency tuning word. On every reference clock a 32-bit phase accumulator adds the tuning word and wraps modulo 2^32, so the output frequency is `tuning_word * f_clk / 2^32`. The top 12 bits of the phase, plus a phase offset taken from the control byte, address a sine table. The table produces a signed 10-bit code for a downstream DAC. The block cannot step the frequency up or down. Every change means loading a fresh word computed as `f_out * 2^32 / f_clk`. For example, the word 0x0009BA3C00 carries the tuning word 0x09BA3C00 (163200000), which gives about 2.95 MHz from a 77.76 MHz clock.

A word comes in either as five bytes on a parallel byte stream or as forty bits on a serial bit stream. It is assembled in a shadow register. Nothing reaches the running oscillator until the whole word has arrived and an apply strobe follows. Both input streams are valid/ready. A beat transfers on a clock edge where both valid and ready are high. Back-pressure is applied only while a complete word waits for its apply strobe. During that time both readies stay low and upstream must hold its beat. The sample and phase outputs have no ready: a DAC takes one code on every clock, so stalling them would break the fixed latency.

An applied word takes effect after a fixed pipeline of 18 reference clocks. Software can therefore predict exactly when the new frequency appears.

Top module: `dds_synth_core`

## Requirements
- R1: On every clock edge after reset, `phase_out` increases by the low 32 bits of the effective control word, modulo 2^32.
- R2: A parallel word is five accepted byte beats. The first byte becomes word bits 39:32, the second bits 31:24, the third bits 23:16, the fourth bits 15:8 and the fifth bits 7:0.
- R3: A serial word is forty accepted bit beats, least significant bit first. The first bit becomes word bit 0 and the fortieth becomes bit 39.
- R4: A high `word_apply` copies a completed, pending word into the active register. When no complete word is pending, `word_apply` has no effect, including when it arrives after only part of a load.
- R5: A high `load_abort` discards all partial progress on both streams and any pending word. A later `word_apply` then leaves the frequency unchanged.
- R6: Both readies are low from the edge that completes a word until it is applied or aborted. If both streams complete on the same edge, the parallel word is kept and the serial word is discarded. The serial bit count still restarts from zero.
- R7: If `word_apply` takes effect at edge k, then the phase steps at edges k+1 to k+17 still use the previous word, and the step at edge k+18 uses the new word.
- R8: At edge n, `sample_out` becomes round(511*sin(2*pi*a/4096)), within 2 LSB, where a = (bits 31:20 of `phase_out` before edge n + 128*offset) mod 4096.
- R9: In the control byte, bits 39:35 are the phase offset in 1/32 turns, bit 34 forces `sample_out` to 0, and bits 33:32 are ignored. Control bits take effect with the same latency as the tuning word.
- R10: After reset, `phase_out` and `sample_out` are 0, both readies are high and the effective word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pbyte_valid | input | 1 | Parallel byte beat valid |
| pbyte_data | input | 8 | Parallel byte, most significant byte first |
| pbyte_ready | output | 1 | Parallel stream ready |
| sbit_valid | input | 1 | Serial bit beat valid |
| sbit_data | input | 1 | Serial bit, least significant bit first |
| sbit_ready | output | 1 | Serial stream ready |
| load_abort | input | 1 | Discard partial and pending loads |
| word_apply | input | 1 | Apply the completed pending word |
| phase_out | output | 32 | Phase accumulator value |
| sample_out | output | 10 | Signed sine code for the DAC |

## Verification
On every cycle, the embedded properties check three things: that the active word moves only after an apply that finds a complete word, that a pending word stays frozen, and that an abort clears all progress. They also check that a pending flag only ever rises on a final beat, and that the quarter-point table entry is full scale. Other behaviour appears only in the bench's scenarios: the exact edge at which the phase step switches, the byte and bit ordering of the two streams, the discarded partial loads, the same-edge race between the streams and the waveform values. For those scenarios, a cycle-accurate model of the requirements runs alongside the design under random and directed loads.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef struct packed {
    logic [4:0] poff;   // phase offset, 1/32 turn per step
    logic       pd;     // force sample to zero
    logic [1:0] rsv;    // ignored
  } ctrl_t;

  // Integer quarter-sine magnitude, rational approximation over a half period.
  function automatic int qsine(int p, int half, int amp);
    longint y;
    longint den;
    y   = longint'(p) * longint'(half - p);
    den = 5 * longint'(half) * longint'(half) - 4 * y;
    return int'((longint'(amp) * 16 * y + den / 2) / den);
  endfunction

endpackage

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
  parameter int NB = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pbyte_valid,
  input  logic [7:0]      pbyte_data,
  output logic            pbyte_ready,
  input  logic            sbit_valid,
  input  logic            sbit_data,
  output logic            sbit_ready,
  input  logic            load_abort,
  input  logic            word_apply,
  output logic [NB*8-1:0] active_word
);
  localparam int WW  = NB * 8;
  localparam int PCW = $clog2(NB);
  localparam int SCW = $clog2(WW);

  logic [PCW-1:0] pcnt;
  logic [SCW-1:0] scnt;
  logic [WW-9:0]  pasm;
  logic [WW-2:0]  sasm;
  logic [WW-1:0]  shadow;
  logic [WW-1:0]  active;
  logic           pend;

  logic pacc, sacc, pdone, sdone;

  assign pbyte_ready = !pend;
  assign sbit_ready  = !pend;
  assign pacc  = pbyte_valid && !pend;
  assign sacc  = sbit_valid && !pend;
  assign pdone = pacc && (pcnt == PCW'(NB - 1));
  assign sdone = sacc && (scnt == SCW'(WW - 1));
  assign active_word = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      scnt   <= '0;
      pasm   <= '0;
      sasm   <= '0;
      shadow <= '0;
      active <= '0;
      pend   <= 1'b0;
    end else if (load_abort) begin
      pcnt <= '0;
      scnt <= '0;
      pend <= 1'b0;
    end else begin
      if (word_apply && pend) begin
        active <= shadow;
        pend   <= 1'b0;
      end
      if (pacc) begin
        pasm <= {pasm[WW-17:0], pbyte_data};
        pcnt <= pdone ? '0 : pcnt + PCW'(1);
      end
      if (sacc) begin
        sasm <= {sbit_data, sasm[WW-2:1]};
        scnt <= sdone ? '0 : scnt + SCW'(1);
      end
      if (pdone) begin
        shadow <= {pasm, pbyte_data};
        pend   <= 1'b1;
      end else if (sdone) begin
        shadow <= {sbit_data, sasm};
        pend   <= 1'b1;
      end
    end
  end

  // R4: the active word moves only after an apply that found a complete word
  p_active_on_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active != $past(active)) |-> $past(word_apply && pend && !load_abort));

  // R4: a word becomes pending only on the final beat of a stream
  p_pend_on_last_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past((pbyte_valid && pcnt == PCW'(NB - 1)) ||
                          (sbit_valid && scnt == SCW'(WW - 1))));

  // R6: a pending word is frozen until applied or aborted
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> $stable(shadow));

  // R5: an abort clears all load progress
  p_abort_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_abort |=> (pcnt == '0 && scnt == '0 && !pend));

endmodule

// File: rtl/dds_word_delay.sv
module dds_word_delay #(
  parameter int W   = 40,
  parameter int STG = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (STG == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] st [STG];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STG; i++) st[i] <= '0;
        end else begin
          st[0] <= din;
          for (int i = 1; i < STG; i++) st[i] <= st[i-1];
        end
      end
      assign dout = st[STG-1];
    end
  endgenerate
endmodule

// File: rtl/dds_phase_sine.sv
module dds_phase_sine
  import dds_pkg::*;
#(
  parameter int PH_W   = 32,
  parameter int ADDR_W = 12,
  parameter int DW     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PH_W+7:0]      word,
  output logic [PH_W-1:0]      phase_out,
  output logic signed [DW-1:0] sample_out
);
  localparam int QN    = 2 ** (ADDR_W - 2);
  localparam int HALF  = 2 ** (ADDR_W - 1);
  localparam int AMP   = 2 ** (DW - 1) - 1;
  localparam int MW    = DW - 1;
  localparam int OFF_W = 5;
  localparam int QW    = ADDR_W - 1;

  ctrl_t           ctrl;
  logic [PH_W-1:0] tw;
  logic            pd;
  logic            unused_rsv;

  assign ctrl       = ctrl_t'(word[PH_W+7:PH_W]);
  assign tw         = word[PH_W-1:0];
  assign pd         = ctrl.pd;
  assign unused_rsv = ^ctrl.rsv;

  // Quarter-wave magnitude table, entries 0..QN inclusive
  logic [MW-1:0] rom [QN+1];
  for (genvar g = 0; g <= QN; g++) begin : g_rom
    assign rom[g] = MW'(qsine(g, HALF, AMP));
  end

  logic [ADDR_W-1:0]    addr;
  logic [QW-1:0]        qidx;
  logic [MW-1:0]        mag;
  logic signed [DW-1:0] smag;

  assign addr = phase_out[PH_W-1 -: ADDR_W] + {ctrl.poff, {(ADDR_W - OFF_W){1'b0}}};
  assign qidx = addr[ADDR_W-2] ? (QW'(QN) - {1'b0, addr[ADDR_W-3:0]})
                               : {1'b0, addr[ADDR_W-3:0]};
  assign mag  = rom[qidx];
  assign smag = $signed({1'b0, mag});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_out  <= '0;
      sample_out <= '0;
    end else begin
      phase_out  <= phase_out + tw;
      sample_out <= pd ? '0 : (addr[ADDR_W-1] ? -smag : smag);
    end
  end

  // R8: the quarter point of the wave is full positive scale
  p_peak_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addr) == ADDR_W'(QN) && !$past(pd)) |-> sample_out == DW'(AMP));

  // R1: a zero tuning word freezes the phase
  p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tw) == '0) |-> phase_out == $past(phase_out));

endmodule

// File: rtl/dds_synth_core.sv
module dds_synth_core #(
  parameter int LAT    = 18,
  parameter int PH_W   = 32,
  parameter int ADDR_W = 12,
  parameter int DW     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pbyte_valid,
  input  logic [7:0]           pbyte_data,
  output logic                 pbyte_ready,
  input  logic                 sbit_valid,
  input  logic                 sbit_data,
  output logic                 sbit_ready,
  input  logic                 load_abort,
  input  logic                 word_apply,
  output logic [PH_W-1:0]      phase_out,
  output logic signed [DW-1:0] sample_out
);
  localparam int WW  = PH_W + 8;
  localparam int NB  = WW / 8;
  localparam int STG = LAT - 1;

  logic [WW-1:0] active_word;
  logic [WW-1:0] eff_word;

  dds_word_loader #(.NB(NB)) u_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .pbyte_valid (pbyte_valid),
    .pbyte_data  (pbyte_data),
    .pbyte_ready (pbyte_ready),
    .sbit_valid  (sbit_valid),
    .sbit_data   (sbit_data),
    .sbit_ready  (sbit_ready),
    .load_abort  (load_abort),
    .word_apply  (word_apply),
    .active_word (active_word)
  );

  dds_word_delay #(.W(WW), .STG(STG)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (active_word),
    .dout  (eff_word)
  );

  dds_phase_sine #(.PH_W(PH_W), .ADDR_W(ADDR_W), .DW(DW)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .word       (eff_word),
    .phase_out  (phase_out),
    .sample_out (sample_out)
  );

  // R6: no beat can be taken while either stream is stalled
  p_ready_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pbyte_ready == sbit_ready);

endmodule

// File: tb/dds_synth_core_tb.sv
module dds_synth_core_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pbyte_valid = 1'b0;
  logic [7:0]        pbyte_data = '0;
  logic              pbyte_ready;
  logic              sbit_valid = 1'b0;
  logic              sbit_data = 1'b0;
  logic              sbit_ready;
  logic              load_abort = 1'b0;
  logic              word_apply = 1'b0;
  logic [31:0]       phase_out;
  logic signed [9:0] sample_out;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  bit  chk_on = 0;

  always #2 clk = ~clk;

  dds_synth_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .pbyte_valid(pbyte_valid), .pbyte_data(pbyte_data), .pbyte_ready(pbyte_ready),
    .sbit_valid(sbit_valid), .sbit_data(sbit_data), .sbit_ready(sbit_ready),
    .load_abort(load_abort), .word_apply(word_apply),
    .phase_out(phase_out), .sample_out(sample_out)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_sine(int a);
    real r;
    r = 511.0 * $sin(6.283185307179586 * real'(a) / 4096.0);
    return int'(r);
  endfunction

  // ---------------- reference model of the requirements ----------------
  logic [31:0] m_phase;
  logic [39:0] m_act, m_sh, m_pa, m_sa, used;
  logic [39:0] ring [32];
  logic [11:0] m_a;
  bit          m_pd, m_pend, pacc, sacc, pdone, sdone;
  int          m_pc, m_sc, m_e;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = '0; m_act = '0; m_sh = '0; m_pa = '0; m_sa = '0;
      m_a = '0; m_pd = 0; m_pend = 0; m_pc = 0; m_sc = 0; m_e = 0;
      for (int i = 0; i < 32; i++) ring[i] = '0;
    end else begin
      used    = ring[(m_e + 14) % 32];             // word applied 18 edges earlier (R7)
      m_a     = m_phase[31:20] + {used[39:35], 7'b0};
      m_pd    = used[34];
      m_phase = m_phase + used[31:0];
      pacc    = pbyte_valid && !m_pend;
      sacc    = sbit_valid && !m_pend;
      if (load_abort) begin
        m_pc = 0; m_sc = 0; m_pend = 0;
      end else begin
        pdone = 0; sdone = 0;
        if (word_apply && m_pend) begin m_act = m_sh; m_pend = 0; end
        if (pacc) begin
          m_pa = {m_pa[31:0], pbyte_data};
          if (m_pc == 4) begin pdone = 1; m_pc = 0; end else m_pc++;
        end
        if (sacc) begin
          m_sa = {sbit_data, m_sa[39:1]};
          if (m_sc == 39) begin sdone = 1; m_sc = 0; end else m_sc++;
        end
        if (pdone) begin m_sh = m_pa; m_pend = 1; end
        else if (sdone) begin m_sh = m_sa; m_pend = 1; end
      end
      ring[m_e % 32] = m_act;
      m_e++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      chk(phase_out == m_phase, "R1 phase", phase_out, m_phase);
      if (m_pd)
        chk(sample_out == 0, "R9 powerdown sample", sample_out, 0);
      else begin
        int e;
        e = exp_sine(int'(m_a));
        chk((int'(sample_out) - e) <= 2 && (e - int'(sample_out)) <= 2,
            "R8 sample", sample_out, e);
      end
      chk(pbyte_ready == !m_pend && sbit_ready == !m_pend, "R6 ready",
          pbyte_ready, !m_pend);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_bytes(logic [39:0] w, int n);
    for (int i = 0; i < n; i++) begin
      pbyte_valid = 1'b1; pbyte_data = w[39 - 8*i -: 8];
      @(negedge clk);
    end
    pbyte_valid = 1'b0;
  endtask

  task automatic send_bits(logic [39:0] w, int n);
    for (int i = 0; i < n; i++) begin
      sbit_valid = 1'b1; sbit_data = w[i];
      @(negedge clk);
    end
    sbit_valid = 1'b0;
  endtask

  task automatic apply_word();
    word_apply = 1'b1; @(negedge clk); word_apply = 1'b0;
  endtask

  task automatic abort_load();
    load_abort = 1'b1; @(negedge clk); load_abort = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_delta(output logic [31:0] d);
    logic [31:0] prev;
    prev = phase_out;
    @(negedge clk);
    d = phase_out - prev;
  endtask

  // word was just applied at the last edge: check the switch edge (R7)
  task automatic latency_check(logic [31:0] old_tw, logic [31:0] new_tw);
    logic [31:0] d;
    for (int j = 1; j <= 18; j++) begin
      step_delta(d);
      if (j == 17) chk(d == old_tw, "R7 old step at k+17", d, old_tw);
      if (j == 18) chk(d == new_tw, "R7 new step at k+18", d, new_tw);
    end
  endtask

  localparam logic [39:0] W1 = 40'h00_09BA3C00;
  localparam logic [39:0] W2 = 40'h2B_12345678;
  localparam logic [39:0] W3 = 40'h00_7FFFFFFF;
  localparam logic [39:0] W4 = 40'h00_00ABCDEF;
  localparam logic [39:0] W5 = 40'h88_40000001;
  localparam logic [39:0] W6 = 40'h04_01000000;

  initial begin
    logic [31:0] d;
    int          seed_v;
    seed_v = $urandom(32'd20240611);
    idle(4);
    rst_n = 1'b1;
    chk(phase_out == 0, "R10 phase after reset", phase_out, 0);
    chk(sample_out == 0, "R10 sample after reset", sample_out, 0);
    chk(pbyte_ready && sbit_ready, "R10 readies after reset", {pbyte_ready, sbit_ready}, 2'b11);
    chk_on = 1;
    idle(3);
    chk(phase_out == 0, "R10 zero word holds phase", phase_out, 0);

    // R2: parallel load of the reference word
    send_bytes(W1, 5);
    apply_word();
    latency_check(32'h0, W1[31:0]);

    // R3 + R6: serial load and back-pressure while pending
    send_bits(W2, 40);
    chk(!pbyte_ready && !sbit_ready, "R6 stalled while pending", {pbyte_ready, sbit_ready}, 0);
    apply_word();
    chk(pbyte_ready && sbit_ready, "R6 ready after apply", {pbyte_ready, sbit_ready}, 2'b11);
    latency_check(W1[31:0], W2[31:0]);

    // R4: apply after four bytes is ignored
    send_bytes(W3, 4);
    apply_word();
    idle(22);
    step_delta(d);
    chk(d == W2[31:0], "R4 partial load ignored", d, W2[31:0]);
    // R5: abort, then one more byte and an apply still change nothing
    abort_load();
    send_bytes(W3, 1);
    apply_word();
    idle(22);
    step_delta(d);
    chk(d == W2[31:0], "R5 aborted load ignored", d, W2[31:0]);
    abort_load();

    // R6: both streams complete on the same edge, parallel wins
    send_bits(W4, 39);
    send_bytes(W5, 4);
    pbyte_valid = 1'b1; pbyte_data = W5[7:0];
    sbit_valid  = 1'b1; sbit_data  = W4[39];
    @(negedge clk);
    pbyte_valid = 1'b0; sbit_valid = 1'b0;
    apply_word();
    idle(20);
    step_delta(d);
    chk(d == W5[31:0], "R6 parallel wins race", d, W5[31:0]);
    // R3: serial counter restarted, a fresh 40-bit load lands intact
    send_bits(W4, 40);
    apply_word();
    idle(20);
    step_delta(d);
    chk(d == W4[31:0], "R3 serial word after race", d, W4[31:0]);

    // R9: power-down bit silences the output
    send_bytes(W6, 5);
    apply_word();
    idle(20);
    chk(sample_out == 0, "R9 power-down output", sample_out, 0);
    idle(3);
    chk(sample_out == 0, "R9 power-down held", sample_out, 0);

    // random loads, both streams, random gaps and apply timing
    for (int it = 0; it < 30; it++) begin
      logic [39:0] w;
      w = {$urandom_range(0, 255), $urandom} & 40'hFB_FFFFFFFF;
      if ($urandom_range(0, 1) == 0) send_bytes(w, 5);
      else send_bits(w, 40);
      idle($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) begin
        abort_load();
        apply_word();
      end else
        apply_word();
      idle($urandom_range(0, 25));
    end
    idle(20);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule